// File: doc/BRIEF.md
# Threshold-Triggered Serial Receive Queue

This block is the receive-side byte queue of a serial controller. A deserialiser upstream presents one byte per frame time on a push strobe. The CPU removes bytes through a register read, modelled here as a pop strobe with combinational read data. The queue keeps a live fill count and compares it with a software-selected trigger level. From that comparison it drives a data-full flag, a receive interrupt request and a one-cycle DMA request.

A frame-tick strobe marks each frame time. When a few bytes are left below the trigger level and no new byte has been stored during two consecutive frame times, the block raises a data-ready flag. Software then knows to drain the remainder.

A push into a full queue loses its byte and sets a sticky overrun bit. While that bit is set, reception is locked off. Software clears the bit with an explicit clear strobe. A queue-reset strobe empties the storage and drops the full and ready flags.

Top module: `rx_trig_fifo`

## Requirements
- R1: The queue holds 16 bytes and returns them in arrival order. `fill_count` shows the number of stored bytes, 0 to 16, and is 0 after reset. `pop_data` shows the oldest byte while the queue is non-empty.
- R2: `trig_sel` selects the trigger level: 2'b00 selects 1 byte, 2'b01 selects 4, 2'b10 selects 8 and 2'b11 selects 14.
- R3: A stored push that leaves the count at or above the trigger level sets `full_flag`. In the same update it raises `dma_req` for exactly one cycle. Both outputs change on the clock edge that takes the push.
- R4: `rx_irq` is high exactly when `rie` is 1 and at least one of `full_flag` and `ready_flag` is set.
- R5: A push with reception enabled, while the count is 16, discards the byte and sets `overrun`. `err_irq` is high exactly when `overrun` is set and at least one of `rie` and `eie` is 1.
- R6: A push is ignored, leaving the count and contents unchanged, while `overrun` is set or while `rx_en` is 0.
- R7: `overrun` stays set until a cycle with `ovr_clear` high. After that cycle, pushes are stored again.
- R8: A `frame_tick` sets `ready_flag` and pulses `dma_req` when all of the following hold: no byte was stored since the previous tick, and none in the tick interval before that; the queue is non-empty; and the count is below the trigger level. Bytes discarded by an overrun do not count as stored.
- R9: `fifo_flush` empties the queue, zeroes the count and clears `full_flag` and `ready_flag`. It takes precedence over a push or pop in the same cycle and does not change `overrun`.
- R10: A pop with `pop_clr` high clears `full_flag` when the new count is below the trigger level, and clears `ready_flag` only when the new count is 0. A pop with `pop_clr` low leaves both flags unchanged.
- R11: A pop while the queue is empty reads 0x00 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Reception enable |
| rie | input | 1 | Receive interrupt enable |
| eie | input | 1 | Error interrupt enable |
| trig_sel | input | 2 | Trigger level code |
| push_valid | input | 1 | Received byte strobe |
| push_data | input | 8 | Received byte |
| pop | input | 1 | CPU read strobe |
| pop_clr | input | 1 | Flag clearing on this pop |
| frame_tick | input | 1 | One-cycle strobe per frame time |
| fifo_flush | input | 1 | Queue reset strobe |
| ovr_clear | input | 1 | Software clear of the overrun bit |
| pop_data | output | 8 | Oldest byte, or 0x00 when empty |
| fill_count | output | 5 | Stored byte count |
| full_flag | output | 1 | Count reached the trigger level |
| ready_flag | output | 1 | Timeout data-ready flag |
| overrun | output | 1 | Sticky overrun bit |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |
| dma_req | output | 1 | One-cycle DMA request |

## Verification
Some properties are checked by the assertions on every cycle:
- the count stays within 16;
- a push that reaches the level raises the full flag and the DMA request;
- an overflowing push sets overrun;
- pushes leave the count alone while locked;
- a flush always empties the queue;
- an empty read yields zero;
- the ready flag rises only after a frame tick.

Other behaviour can be shown only by the bench's scenarios against its queue-based model. This covers the byte order through wrap-around, and the exact two-interval quiet window before data-ready. It also covers the different clearing points of the full and ready flags under `pop_clr`, and reception resuming after an overrun clear.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        TRIG_1  = 2'b00,
        TRIG_4  = 2'b01,
        TRIG_8  = 2'b10,
        TRIG_14 = 2'b11
    } trig_code_e;

    typedef struct packed {
        logic full;
        logic ready;
        logic ovr;
        logic dma;
    } rxf_state_t;

    function automatic int unsigned trig_level(input logic [1:0] code);
        case (trig_code_e'(code))
            TRIG_1:  return 1;
            TRIG_4:  return 4;
            TRIG_8:  return 8;
            TRIG_14: return 14;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clr) mem[wr_ptr] <= wr_data;
    end

    assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/rxf_level.sv
module rxf_level #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_next
);
    always_comb begin
        if (clr) count_next = '0;
        else     count_next = count + CW'(inc) - CW'(dec);
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count_next;
    end

endmodule

// File: rtl/rxf_timeout.sv
module rxf_timeout (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic arrival,
    input  logic tick,
    output logic quiet
);
    logic got_cur, got_prev, got_eff;

    assign got_eff = got_cur | arrival;
    assign quiet   = ~got_eff & ~got_prev;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            got_cur  <= 1'b0;
            got_prev <= 1'b0;
        end else if (tick) begin
            got_prev <= got_eff;
            got_cur  <= 1'b0;
        end else begin
            got_cur  <= got_eff;
        end
    end

endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo
    import rxf_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              rie,
    input  logic              eie,
    input  logic [1:0]        trig_sel,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              pop_clr,
    input  logic              frame_tick,
    input  logic              fifo_flush,
    input  logic              ovr_clear,
    output logic [DATA_W-1:0] pop_data,
    output logic [CW-1:0]     fill_count,
    output logic              full_flag,
    output logic              ready_flag,
    output logic              overrun,
    output logic              rx_irq,
    output logic              err_irq,
    output logic              dma_req
);
    rxf_state_t st_q, st_d;

    logic [CW-1:0]     cnt, cnt_n;
    logic [DATA_W-1:0] head_byte;
    logic              accept, ovf, wr, rd, quiet;
    int unsigned       thr;

    assign thr    = trig_level(trig_sel);
    assign accept = push_valid & rx_en & ~st_q.ovr & ~fifo_flush;
    assign ovf    = accept & (cnt == CW'(DEPTH));
    assign wr     = accept & ~ovf;
    assign rd     = pop & ~fifo_flush & (cnt != '0);

    rxf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) store_i (
        .clk(clk), .rst(rst), .clr(fifo_flush),
        .wr_en(wr), .wr_data(push_data),
        .rd_en(rd), .rd_data(head_byte)
    );

    rxf_level #(.DEPTH(DEPTH)) level_i (
        .clk(clk), .rst(rst), .clr(fifo_flush),
        .inc(wr), .dec(rd),
        .count(cnt), .count_next(cnt_n)
    );

    rxf_timeout timeout_i (
        .clk(clk), .rst(rst), .clr(fifo_flush),
        .arrival(wr), .tick(frame_tick & ~fifo_flush),
        .quiet(quiet)
    );

    always_comb begin
        st_d     = st_q;
        st_d.dma = 1'b0;
        if (fifo_flush) begin
            st_d.full  = 1'b0;
            st_d.ready = 1'b0;
        end else begin
            if (wr && (int'(cnt_n) >= int'(thr))) begin
                st_d.full = 1'b1;
                st_d.dma  = 1'b1;
            end
            if (rd && pop_clr) begin
                if (int'(cnt_n) < int'(thr)) st_d.full  = 1'b0;
                if (cnt_n == '0)             st_d.ready = 1'b0;
            end
            if (frame_tick && quiet && (cnt_n != '0) &&
                (int'(cnt_n) < int'(thr)) && !st_d.ready) begin
                st_d.ready = 1'b1;
                st_d.dma   = 1'b1;
            end
        end
        if (ovr_clear) st_d.ovr = 1'b0;
        if (ovf)       st_d.ovr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pop_data   = (cnt != '0) ? head_byte : '0;
    assign fill_count = cnt;
    assign full_flag  = st_q.full;
    assign ready_flag = st_q.ready;
    assign overrun    = st_q.ovr;
    assign dma_req    = st_q.dma;
    assign rx_irq     = rie & (st_q.full | st_q.ready);
    assign err_irq    = (rie | eie) & st_q.ovr;

endmodule

// File: rtl/rx_trig_fifo_chk.sv
module rx_trig_fifo_chk
    import rxf_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_en,
    input logic              rie,
    input logic [1:0]        trig_sel,
    input logic              push_valid,
    input logic              pop,
    input logic              frame_tick,
    input logic              fifo_flush,
    input logic              ovr_clear,
    input logic [DATA_W-1:0] pop_data,
    input logic [CW-1:0]     fill_count,
    input logic              full_flag,
    input logic              ready_flag,
    input logic              overrun,
    input logic              rx_irq,
    input logic              err_irq,
    input logic              dma_req
);
    int unsigned lvl;
    logic        push_ok;

    assign lvl     = trig_level(trig_sel);
    assign push_ok = push_valid && rx_en && !overrun && !fifo_flush;

    p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
        int'(fill_count) <= int'(DEPTH));

    p_full_dma_r3: assert property (@(posedge clk) disable iff (rst)
        (push_ok && !pop && (int'(fill_count) < int'(DEPTH)) &&
         (int'(fill_count) + 1 >= int'(lvl)))
        |=> (full_flag && dma_req));

    p_irq_off_r4: assert property (@(posedge clk) disable iff (rst)
        !rie |-> !rx_irq);

    p_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (push_ok && !pop && (int'(fill_count) == int'(DEPTH)))
        |=> (overrun && (int'(fill_count) == int'(DEPTH))));

    p_err_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !overrun |-> !err_irq);

    p_locked_r6: assert property (@(posedge clk) disable iff (rst)
        (overrun && !pop && !fifo_flush) |=> $stable(fill_count));

    p_resume_r7: assert property (@(posedge clk) disable iff (rst)
        (overrun && ovr_clear) |=> !overrun);

    p_ready_after_tick_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_flag) |-> $past(frame_tick));

    p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
        fifo_flush |=> ((fill_count == '0) && !full_flag && !ready_flag));

    p_empty_read_r11: assert property (@(posedge clk) disable iff (rst)
        (fill_count == '0) |-> (pop_data == '0));

endmodule

bind rx_trig_fifo rx_trig_fifo_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rie(rie), .trig_sel(trig_sel),
    .push_valid(push_valid), .pop(pop), .frame_tick(frame_tick),
    .fifo_flush(fifo_flush), .ovr_clear(ovr_clear), .pop_data(pop_data),
    .fill_count(fill_count), .full_flag(full_flag), .ready_flag(ready_flag),
    .overrun(overrun), .rx_irq(rx_irq), .err_irq(err_irq), .dma_req(dma_req)
);

// File: tb/rx_trig_fifo_tb_top.sv
module rx_trig_fifo_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b1, rie = 1'b0, eie = 1'b0;
    logic [1:0] trig_sel = 2'b00;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = 8'h00;
    logic       pop = 1'b0, pop_clr = 1'b0, frame_tick = 1'b0;
    logic       fifo_flush = 1'b0, ovr_clear = 1'b0;
    logic [7:0] pop_data;
    logic [4:0] fill_count;
    logic       full_flag, ready_flag, overrun, rx_irq, err_irq, dma_req;

    int total = 0;
    int bad   = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rx_trig_fifo dut_i (
        .clk(clk), .rst(rst), .rx_en(rx_en), .rie(rie), .eie(eie),
        .trig_sel(trig_sel), .push_valid(push_valid), .push_data(push_data),
        .pop(pop), .pop_clr(pop_clr), .frame_tick(frame_tick),
        .fifo_flush(fifo_flush), .ovr_clear(ovr_clear), .pop_data(pop_data),
        .fill_count(fill_count), .full_flag(full_flag), .ready_flag(ready_flag),
        .overrun(overrun), .rx_irq(rx_irq), .err_irq(err_irq), .dma_req(dma_req)
    );

    // behavioural reference model
    byte unsigned mq[$];
    bit m_full, m_ready, m_ovr, m_dma, m_gc, m_gp;

    function automatic int level_of(input logic [1:0] c);
        int t;
        case (c)
            2'b00:   t = 1;
            2'b01:   t = 4;
            2'b10:   t = 8;
            default: t = 14;
        endcase
        return t;
    endfunction

    always @(posedge clk) begin
        int  t, n;
        bit  acc, over, took, stored;
        if (rst) begin
            mq.delete();
            m_full = 0; m_ready = 0; m_ovr = 0; m_dma = 0; m_gc = 0; m_gp = 0;
        end else begin
            t = level_of(trig_sel);
            m_dma = 0;
            acc = push_valid && rx_en && !m_ovr && !fifo_flush;
            over = acc && (mq.size() == 16);
            if (fifo_flush) begin
                mq.delete();
                m_full = 0; m_ready = 0; m_gc = 0; m_gp = 0;
            end else begin
                took = pop && (mq.size() > 0);
                stored = acc && !over;
                if (took) void'(mq.pop_front());
                if (stored) mq.push_back(push_data);
                n = mq.size();
                if (stored && n >= t) begin m_full = 1; m_dma = 1; end
                if (took && pop_clr) begin
                    if (n < t)  m_full = 0;
                    if (n == 0) m_ready = 0;
                end
                m_gc = m_gc || stored;
                if (frame_tick) begin
                    if (!m_gc && !m_gp && n > 0 && n < t && !m_ready) begin
                        m_ready = 1; m_dma = 1;
                    end
                    m_gp = m_gc;
                    m_gc = 0;
                end
            end
            if (ovr_clear) m_ovr = 0;
            if (over) m_ovr = 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (model_on && !done) begin
            chk("R1 fill_count", int'(fill_count), mq.size());
            chk("R1 pop_data", int'(pop_data), (mq.size() > 0) ? int'(mq[0]) : 0);
            chk("R3 full_flag", int'(full_flag), int'(m_full));
            chk("R8 ready_flag", int'(ready_flag), int'(m_ready));
            chk("R3 dma_req", int'(dma_req), int'(m_dma));
            chk("R5 overrun", int'(overrun), int'(m_ovr));
            chk("R4 rx_irq", int'(rx_irq), int'(rie && (m_full || m_ready)));
            chk("R5 err_irq", int'(err_irq), int'((rie || eie) && m_ovr));
        end
    end

    task automatic do_push(input logic [7:0] b);
        push_valid = 1; push_data = b;
        @(negedge clk); push_valid = 0;
    endtask
    task automatic do_pop(input logic clr);
        pop = 1; pop_clr = clr;
        @(negedge clk); pop = 0; pop_clr = 0;
    endtask
    task automatic do_tick();
        frame_tick = 1; @(negedge clk); frame_tick = 0;
    endtask
    task automatic do_flush();
        fifo_flush = 1; @(negedge clk); fifo_flush = 0;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        model_on = 1;
        // reset state, R1
        chk("R1 reset count", int'(fill_count), 0);
        chk("R1 reset flags", int'({full_flag, ready_flag, overrun, dma_req}), 0);

        // R2 / R3: level 4
        trig_sel = 2'b01; rie = 1;
        do_push(8'h11); do_push(8'h22); do_push(8'h33);
        chk("R2 below level 4", int'(full_flag), 0);
        do_push(8'h44);
        chk("R3 full at level 4", int'(full_flag), 1);
        chk("R3 dma pulse", int'(dma_req), 1);
        chk("R4 irq with full", int'(rx_irq), 1);
        @(negedge clk);
        chk("R3 dma one cycle", int'(dma_req), 0);
        chk("R1 head byte", int'(pop_data), 8'h11);
        do_pop(1'b1);
        chk("R10 full clears below level", int'(full_flag), 0);
        chk("R1 second byte", int'(pop_data), 8'h22);
        do_flush();

        // R8: level 8, quiet window
        trig_sel = 2'b10;
        do_push(8'hA1); do_push(8'hA2);
        do_tick();
        chk("R8 no ready with arrival", int'(ready_flag), 0);
        do_tick();
        chk("R8 no ready after one quiet", int'(ready_flag), 0);
        do_tick();
        chk("R8 ready after two quiet", int'(ready_flag), 1);
        chk("R4 irq with ready", int'(rx_irq), 1);
        // R10: pops
        do_pop(1'b0);
        chk("R10 no clear without pop_clr", int'(ready_flag), 1);
        do_pop(1'b1);
        chk("R10 ready clears at zero", int'(ready_flag), 0);
        chk("R4 irq drops", int'(rx_irq), 0);

        // R11: empty pop
        chk("R11 empty read", int'(pop_data), 0);
        do_pop(1'b1);
        chk("R11 count unchanged", int'(fill_count), 0);

        // R5 / R6 / R7: overrun
        trig_sel = 2'b11; rie = 0; eie = 1;
        for (int i = 0; i < 16; i++) do_push(8'(i + 8'h30));
        chk("R2 full at level 14", int'(full_flag), 1);
        chk("R4 irq masked", int'(rx_irq), 0);
        do_push(8'hEE);
        chk("R5 overrun set", int'(overrun), 1);
        chk("R5 count kept", int'(fill_count), 16);
        chk("R5 err irq", int'(err_irq), 1);
        do_pop(1'b0);
        do_push(8'hEF);
        chk("R6 locked push ignored", int'(fill_count), 15);
        ovr_clear = 1; @(negedge clk); ovr_clear = 0;
        chk("R7 overrun cleared", int'(overrun), 0);
        do_push(8'hF0);
        chk("R7 reception resumes", int'(fill_count), 16);
        // R9: flush
        do_flush();
        chk("R9 flush count", int'(fill_count), 0);
        chk("R9 flush flags", int'({full_flag, ready_flag}), 0);
        // R6: rx disabled
        rx_en = 0;
        do_push(8'h55);
        chk("R6 disabled push ignored", int'(fill_count), 0);
        rx_en = 1;

        // random traffic against the model
        for (int c = 0; c < 3000; c++) begin
            push_valid = ($urandom_range(99) < 55);
            push_data  = 8'($urandom);
            pop        = ($urandom_range(99) < 40);
            pop_clr    = $urandom_range(1);
            frame_tick = ($urandom_range(99) < 20);
            fifo_flush = ($urandom_range(99) < 2);
            ovr_clear  = ($urandom_range(99) < 4);
            rx_en      = ($urandom_range(99) < 95);
            if ($urandom_range(99) < 3) trig_sel = 2'($urandom);
            rie = $urandom_range(1);
            eie = $urandom_range(1);
            @(negedge clk);
        end
        push_valid = 0; pop = 0; frame_tick = 0; fifo_flush = 0; ovr_clear = 0;
        @(negedge clk);
        #2;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule